// File: doc/BRIEF.md
# GPIO Data Register Bank

This block is the data path of a 16-pin general-purpose I/O port. It sits behind a plain 32-bit memory-mapped register port with single-cycle access and drives the pad logic. For each pin it holds a direction bit and an output value, and it returns the synchronized pin level. A direction bit of 1 makes the pin an input, so every pad is high-impedance after reset. Software can load the output register as a whole word. It can also raise or lower chosen bits with no read-modify-write, through two alias offsets: one sets bits and one clears them.

Pin levels pass through a two-flop synchronizer before they reach the input register. A read of that register therefore shows the pin as it was two clock edges earlier. A write takes effect at the clock edge that ends the access cycle. Read data is combinational from the address and is driven only while a read is requested. The register select is an enumerated decode with six values: none, direction, output, set alias, clear alias and input. Both the write path and the read mux branch on this select.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, every direction bit is 1, the output register is 0, and `pad_oe` and `pad_out` are all zero.
- R2: The direction register sits at offset 0x10 and reads back as written. Each `pad_oe` bit is 1 exactly when its direction bit is 0 (output), from the edge after the write.
- R3: A write to offset 0x14 loads the output register with the low 16 bits of the write data, and a read of 0x14 returns it. `pad_out` always equals the output register.
- R4: A write to offset 0x18 sets each output-register bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R5: A write to offset 0x1C clears each output-register bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R6: A read of offset 0x18 or 0x1C returns the output register, not the pin levels.
- R7: A read of offset 0x20 returns `pad_in` as sampled two clock edges earlier, whatever the direction and output settings are. Writes to 0x20 change no register.
- R8: Bits 31..16 of every register read as 0, and writes to those bits have no effect.
- R9: A read of any other offset, including a misaligned one, returns 0, and writes to such offsets change no register. `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read request; read data is valid in the same cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read is requested |
| pad_in | input | 16 | Pin levels from the pads (asynchronous) |
| pad_out | output | 16 | Output value toward each pad |
| pad_oe | output | 16 | Output enable toward each pad, 1 = drive |

## Verification
The set and clear aliases are each driven with checkerboard masks on top of a non-trivial output value. A lost-bit or inverted-mask fault then shows up both in the bits written with 1 and in the bits written with 0. The direction register is tried with mixed patterns, and with upper-half-only data, which tells a correct inversion onto `pad_oe` apart from a reserved-bit leak. The input register is read in the same cycle as a pin change and after one and two edges, which separates a correct two-stage latency from a latency of one or three stages. Writes of all-ones to unmapped, misaligned and read-only offsets are followed by read-back of every register, so stray decodes become visible.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

    // Byte offsets; software depends on these exact values.
    localparam logic [7:0] OFS_DIR = 8'h10;
    localparam logic [7:0] OFS_OUT = 8'h14;
    localparam logic [7:0] OFS_SET = 8'h18;
    localparam logic [7:0] OFS_CLR = 8'h1C;
    localparam logic [7:0] OFS_IN  = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_OUT  = 3'd2,
        SEL_SET  = 3'd3,
        SEL_CLR  = 3'd4,
        SEL_IN   = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if      (addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
        else if (addr == ADDR_W'(OFS_OUT)) sel = SEL_OUT;
        else if (addr == ADDR_W'(OFS_SET)) sel = SEL_SET;
        else if (addr == ADDR_W'(OFS_CLR)) sel = SEL_CLR;
        else if (addr == ADDR_W'(OFS_IN))  sel = SEL_IN;
        else                               sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_sel_e        sel,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] out_q
);
    logic [PINS-1:0] dir_d;
    logic [PINS-1:0] out_d;

    always_comb begin
        dir_d = dir_q;
        out_d = out_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DIR: dir_d = wdata;
                SEL_OUT: out_d = wdata;
                SEL_SET: out_d = out_q | wdata;
                SEL_CLR: out_d = out_q & ~wdata;
                SEL_IN, SEL_NONE: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            out_q <= '0;
        end else begin
            dir_q <= dir_d;
            out_q <= out_d;
        end
    end

    // R4
    set_forces_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    // R4
    set_keeps_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SET) |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

    // R5
    clr_forces_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CLR) |=> ((out_q & $past(wdata)) == '0));

    // R5
    clr_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CLR) |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || sel == SEL_IN || sel == SEL_NONE) |=> ($stable(dir_q) && $stable(out_q)));
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned PINS        = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    reg_sel_e        sel;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] rd_field;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_ctrl_regs #(.PINS(PINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata[PINS-1:0]),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    assign pad_oe  = ~dir_q;
    assign pad_out = out_q;

    always_comb begin
        rd_field = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_DIR:                  rd_field = dir_q;
                SEL_OUT, SEL_SET, SEL_CLR: rd_field = out_q;
                SEL_IN:                   rd_field = pin_sync;
                SEL_NONE:                 rd_field = '0;
                default:                  rd_field = '0;
            endcase
        end
    end

    assign bus_rdata = DATA_W'(rd_field);

    // Cycles since reset, saturating; used only to qualify the latency check.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R2
    oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_DIR) |=> (pad_oe == ~$past(bus_wdata[PINS-1:0])));

    // R3
    out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_OUT) |=> (pad_out == $past(bus_wdata[PINS-1:0])));

    // R9
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || sel == SEL_NONE) |-> (bus_rdata == '0));

    generate
        if (PINS < DATA_W) begin : g_rsvd
            // R8
            rsvd_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdata[DATA_W-1:PINS] == '0);
        end
        if (SYNC_STAGES == 2) begin : g_lat
            // R7
            in_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_rd && sel == SEL_IN && warm_q >= 2'd2)
                    |-> (bus_rdata[PINS-1:0] == $past(pad_in, 2)));
        end
    endgenerate
endmodule

// File: tb/gpio_regbank_bench.sv
`timescale 1ns/1ps
module gpio_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    gpio_regbank u_gpio_regbank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        rd(8'h10, d); chk("R1 dir", d, 32'h0000_FFFF);
        rd(8'h14, d); chk("R1 out", d, 32'h0);
        chk("R9 idle rdata", bus_rdata, 32'h0);
    endtask

    task automatic t_direction();
        logic [31:0] d;
        wr(8'h10, 32'h0000_A50F);
        rd(8'h10, d); chk("R2 dir readback", d, 32'h0000_A50F);
        chk("R2 pad_oe", 32'(pad_oe), 32'h0000_5AF0);
        wr(8'h10, 32'h0000_00FF);
        chk("R2 pad_oe second", 32'(pad_oe), 32'h0000_FF00);
    endtask

    task automatic t_output_write();
        logic [31:0] d;
        wr(8'h14, 32'h0000_3C96);
        rd(8'h14, d); chk("R3 out readback", d, 32'h0000_3C96);
        chk("R3 pad_out", 32'(pad_out), 32'h0000_3C96);
    endtask

    task automatic t_set_alias();
        logic [31:0] d;
        wr(8'h14, 32'h0000_0F0F);
        wr(8'h18, 32'h0000_5555);
        chk("R4 set alias", 32'(pad_out), 32'h0000_5F5F);
        wr(8'h18, 32'h0000_0000);
        chk("R4 set zero no effect", 32'(pad_out), 32'h0000_5F5F);
    endtask

    task automatic t_clear_alias();
        wr(8'h14, 32'h0000_F0F0);
        wr(8'h1C, 32'h0000_AAAA);
        chk("R5 clear alias", 32'(pad_out), 32'h0000_5050);
        wr(8'h1C, 32'h0000_0000);
        chk("R5 clear zero no effect", 32'(pad_out), 32'h0000_5050);
    endtask

    task automatic t_alias_reads();
        logic [31:0] d;
        pad_in = 16'hFFFF;
        wr(8'h14, 32'h0000_1234);
        rd(8'h18, d); chk("R6 set alias read", d, 32'h0000_1234);
        rd(8'h1C, d); chk("R6 clear alias read", d, 32'h0000_1234);
    endtask

    task automatic t_input_sync();
        logic [31:0] d;
        wr(8'h10, 32'h0000_0000);
        wr(8'h14, 32'h0000_FFFF);
        @(negedge clk); pad_in = 16'h0000;
        repeat (3) @(negedge clk);
        pad_in = 16'hC3A5;
        bus_rd = 1'b1; bus_addr = 8'h20;
        #1 chk("R7 in same cycle", bus_rdata, 32'h0);
        @(negedge clk);
        #1 chk("R7 in after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        #1 chk("R7 in after two edges", bus_rdata, 32'h0000_C3A5);
        bus_rd = 1'b0;
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R7 write to in leaves dir", d, 32'h0);
        rd(8'h14, d); chk("R7 write to in leaves out", d, 32'h0000_FFFF);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(8'h10, 32'hFFFF_0000);
        rd(8'h10, d); chk("R8 dir upper ignored", d, 32'h0);
        chk("R8 pad_oe", 32'(pad_oe), 32'h0000_FFFF);
        wr(8'h14, 32'hABCD_0001);
        rd(8'h14, d); chk("R8 out upper zero", d, 32'h0000_0001);
        rd(8'h20, d); chk("R8 in upper zero", d[31:16], 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h10, 32'h0000_1111);
        wr(8'h14, 32'h0000_2222);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h12, 32'hFFFF_FFFF);
        wr(8'h1B, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R9 dir unchanged", d, 32'h0000_1111);
        rd(8'h14, d); chk("R9 out unchanged", d, 32'h0000_2222);
        rd(8'h24, d); chk("R9 unmapped read", d, 32'h0);
        rd(8'h16, d); chk("R9 misaligned read", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_output_write();
        t_set_alias();
        t_clear_alias();
        t_alias_reads();
        t_input_sync();
        t_reserved();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule